// File: doc/BRIEF.md
# Bias and Pooling Result Collector

The collector sits between a group of processing elements and the on-chip feature memory. Each element works on one output map. When it finishes a dot product it presents the raw sum on its own result lane. The collector holds each arriving sum. It fetches the bias for that element's kernel from a synchronous bias memory and adds it with saturation. It then writes the activation into feature memory. The storage order puts the map index innermost, then the column, then the row.

A configuration word is loaded before each layer. It gives the pre-pool row length, the total number of output maps, the map index served by element 0, and a pooling selector. With pooling off, every biased result is written at once. With a 2x2 or 3x3 window selected, each element's results are read as a raster scan of its map. A partial maximum is kept per window column in a small local buffer. Only the maximum of a completed window is written. Results that arrive from several elements in the same cycle are handled one per cycle, lowest element index first.

Usage rules:
- An element may present a new result only once its previous one has been taken. Spacing results from one element at least NUM_PE cycles apart meets this rule.
- The row length must be a multiple of the window side and at most twice BUF_DEPTH.

Top module: `result_collector`

## Requirements
- R1: While rst_n is low, and afterwards until a result arrives, fm_we and bias_rd_en stay low.
- R2: With pooling off, each result from element p is written once. The data is the saturated sum of the result and the bias. The address is n*cfg_map_cnt + cfg_map_base + p, where n counts element p's earlier results since the last configuration load. With no contention, fm_we is high in the cycle after the second rising edge following the edge that samples pe_valid.
- R3: The bias for element p is read at address cfg_map_base + p. bias_rd_en is raised in the cycle after the result is sampled, and the read data is used one cycle later.
- R4: The sum is signed, RES_W bits wide. It clamps to the largest positive value on overflow and to the most negative value on underflow.
- R5: Results sampled in the same cycle are written on consecutive cycles in ascending element index. A result is never lost if its element obeys the spacing rule.
- R6: With cfg_pool = 1 (2x2), element p's results form a raster of cfg_row_len columns cut into non-overlapping 2x2 windows. Each completed window gives one write of the largest of its four biased values. The address is k*cfg_map_cnt + cfg_map_base + p, where k is the window's raster index in the pooled map. Other results produce no write.
- R7: With cfg_pool = 2 (3x3), the behaviour is the same as R6 over 3x3 windows.
- R8: cfg_pool = 0 and cfg_pool = 3 both mean no pooling.
- R9: A pulse on cfg_load restarts every element's count at index 0 and drops any partly filled window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Captures the configuration fields |
| cfg_pool | input | 2 | Pooling selector: 0 off, 1 2x2, 2 3x3, 3 off |
| cfg_row_len | input | COL_W | Columns per row of the map before pooling |
| cfg_map_cnt | input | MAP_W | Total number of output maps in the layer |
| cfg_map_base | input | MAP_W | Map index served by element 0 |
| pe_valid | input | NUM_PE | One bit per element: a result is present |
| pe_result | input | NUM_PE*RES_W | Signed dot-product results, element p at bits p*RES_W and up |
| bias_rd_en | output | 1 | Bias memory read request |
| bias_rd_addr | output | MAP_W | Bias memory read address |
| bias_rd_data | input | RES_W | Signed bias, valid one cycle after the request |
| fm_we | output | 1 | Feature memory write strobe |
| fm_addr | output | ADDR_W | Feature memory write address |
| fm_wdata | output | RES_W | Activation written |

## Verification
The bound checker watches the cycle-level properties on every cycle. These are: the lowest-index-first grant, that no held result is overwritten, and that a bias request always comes before the stage that consumes it, which in turn comes before each write. It also checks that every bias address stays inside the element group. The bench scenarios alone show the values. These are the saturated sums, the window maxima and the addresses in map-innermost order, the exact write cycle and order under contention, and the restart after a configuration load. They are compared against a bench model that rebuilds each element's map and recomputes each window maximum directly.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    POOL_OFF = 2'd0,
    POOL_W2  = 2'd1,
    POOL_W3  = 2'd2,
    POOL_ALT = 2'd3
  } pool_sel_e;

  // Window side in samples for a pooling selector; 1 means no pooling.
  function automatic logic [1:0] window_side(input logic [1:0] sel);
    case (pool_sel_e'(sel))
      POOL_W2: return 2'd2;
      POOL_W3: return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/rc_grant_arbiter.sv
module rc_grant_arbiter #(
  parameter int NUM_PE = 4,
  parameter int RES_W  = 16,
  localparam int IDX_W = $clog2(NUM_PE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PE-1:0]       pe_valid,
  input  logic [NUM_PE*RES_W-1:0] pe_result,
  output logic [NUM_PE-1:0]       pending,
  output logic [NUM_PE-1:0]       grant_oh,
  output logic                    grant_valid,
  output logic [IDX_W-1:0]        grant_idx,
  output logic [RES_W-1:0]        grant_data
);
  logic [RES_W-1:0] held [NUM_PE];

  // Fixed priority: lowest element index wins.
  always_comb begin
    grant_oh    = '0;
    grant_valid = 1'b0;
    grant_idx   = '0;
    for (int i = 0; i < NUM_PE; i++) begin
      if (pending[i] && !grant_valid) begin
        grant_valid = 1'b1;
        grant_idx   = IDX_W'(i);
        grant_oh[i] = 1'b1;
      end
    end
  end

  assign grant_data = held[grant_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~grant_oh) | pe_valid;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PE; i++) begin
      if (pe_valid[i]) held[i] <= pe_result[i*RES_W +: RES_W];
    end
  end
endmodule

// File: rtl/rc_window_tracker.sv
module rc_window_tracker #(
  parameter int NUM_PE = 4,
  parameter int COL_W  = 6,
  parameter int PX_W   = 4,
  parameter int ADDR_W = 14,
  localparam int IDX_W = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [1:0]        win,
  input  logic [COL_W-1:0]  row_len,
  input  logic              grant_valid,
  input  logic [IDX_W-1:0]  grant_idx,
  output logic              sel_first,
  output logic              sel_last,
  output logic [PX_W-1:0]   sel_px,
  output logic [ADDR_W-1:0] sel_oidx
);
  // Per-element raster position: column, column inside window, row inside
  // window, pooled column and count of writes issued.
  logic [COL_W-1:0]  col_q  [NUM_PE];
  logic [1:0]        cx_q   [NUM_PE];
  logic [1:0]        ry_q   [NUM_PE];
  logic [PX_W-1:0]   px_q   [NUM_PE];
  logic [ADDR_W-1:0] oidx_q [NUM_PE];

  logic end_row, end_cx, end_ry;

  assign end_row   = col_q[grant_idx] == row_len - COL_W'(1);
  assign end_cx    = cx_q[grant_idx] == win - 2'd1;
  assign end_ry    = ry_q[grant_idx] == win - 2'd1;
  assign sel_first = (cx_q[grant_idx] == 2'd0) && (ry_q[grant_idx] == 2'd0);
  assign sel_last  = end_cx && end_ry;
  assign sel_px    = px_q[grant_idx];
  assign sel_oidx  = oidx_q[grant_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PE; i++) begin
        col_q[i] <= '0; cx_q[i] <= '0; ry_q[i] <= '0; px_q[i] <= '0; oidx_q[i] <= '0;
      end
    end else if (restart) begin
      for (int i = 0; i < NUM_PE; i++) begin
        col_q[i] <= '0; cx_q[i] <= '0; ry_q[i] <= '0; px_q[i] <= '0; oidx_q[i] <= '0;
      end
    end else if (grant_valid) begin
      if (end_row) begin
        col_q[grant_idx] <= '0;
        cx_q[grant_idx]  <= '0;
        px_q[grant_idx]  <= '0;
        ry_q[grant_idx]  <= end_ry ? 2'd0 : ry_q[grant_idx] + 2'd1;
      end else begin
        col_q[grant_idx] <= col_q[grant_idx] + COL_W'(1);
        cx_q[grant_idx]  <= end_cx ? 2'd0 : cx_q[grant_idx] + 2'd1;
        if (end_cx && win != 2'd1) px_q[grant_idx] <= px_q[grant_idx] + PX_W'(1);
      end
      if (sel_last) oidx_q[grant_idx] <= oidx_q[grant_idx] + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/rc_bias_pool_stage.sv
module rc_bias_pool_stage #(
  parameter int NUM_PE = 4,
  parameter int RES_W  = 16,
  parameter int MAP_W  = 6,
  parameter int ADDR_W = 14,
  parameter int PX_W   = 4,
  localparam int IDX_W = $clog2(NUM_PE),
  localparam int WIDE  = ADDR_W + MAP_W,
  localparam int DEPTH = 1 << PX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  input  logic [IDX_W-1:0]  grant_idx,
  input  logic [RES_W-1:0]  grant_data,
  input  logic              sel_first,
  input  logic              sel_last,
  input  logic [PX_W-1:0]   sel_px,
  input  logic [ADDR_W-1:0] sel_oidx,
  input  logic [RES_W-1:0]  bias_data,
  input  logic [MAP_W-1:0]  map_cnt,
  input  logic [MAP_W-1:0]  map_base,
  output logic              s1_valid,
  output logic              fm_we,
  output logic [ADDR_W-1:0] fm_addr,
  output logic [RES_W-1:0]  fm_wdata
);
  function automatic logic [RES_W-1:0] sat_sum(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b);
    logic [RES_W:0] t;
    t = {a[RES_W-1], a} + {b[RES_W-1], b};
    if (t[RES_W] != t[RES_W-1])
      return t[RES_W] ? {1'b1, {(RES_W-1){1'b0}}} : {1'b0, {(RES_W-1){1'b1}}};
    return t[RES_W-1:0];
  endfunction

  function automatic logic [RES_W-1:0] larger(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b);
    return ($signed(a) > $signed(b)) ? a : b;
  endfunction

  function automatic logic [ADDR_W-1:0] map_addr(input logic [ADDR_W-1:0] idx, input logic [MAP_W-1:0] cnt,
                                                 input logic [MAP_W-1:0] base, input logic [IDX_W-1:0] pe);
    logic [WIDE-1:0] full;
    full = WIDE'(idx) * WIDE'(cnt) + WIDE'(base) + WIDE'(pe);
    return full[ADDR_W-1:0];
  endfunction

  logic              s1_first, s1_last;
  logic [IDX_W-1:0]  s1_pe;
  logic [RES_W-1:0]  s1_data;
  logic [PX_W-1:0]   s1_px;
  logic [ADDR_W-1:0] s1_oidx;
  logic [RES_W-1:0]  pbuf [NUM_PE][DEPTH];
  logic [RES_W-1:0]  biased, pooled;

  assign biased = sat_sum(s1_data, bias_data);
  assign pooled = s1_first ? biased : larger(pbuf[s1_pe][s1_px], biased);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0; s1_pe <= '0;
      s1_data <= '0; s1_px <= '0; s1_oidx <= '0;
    end else begin
      s1_valid <= grant_valid;
      s1_first <= sel_first;
      s1_last  <= sel_last;
      s1_pe    <= grant_idx;
      s1_data  <= grant_data;
      s1_px    <= sel_px;
      s1_oidx  <= sel_oidx;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid && !s1_last) pbuf[s1_pe][s1_px] <= pooled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fm_we <= 1'b0; fm_addr <= '0; fm_wdata <= '0;
    end else begin
      fm_we    <= s1_valid && s1_last;
      fm_addr  <= map_addr(s1_oidx, map_cnt, map_base, s1_pe);
      fm_wdata <= pooled;
    end
  end
endmodule

// File: rtl/result_collector.sv
module result_collector #(
  parameter int NUM_PE    = 4,
  parameter int RES_W     = 16,
  parameter int MAP_W     = 6,
  parameter int COL_W     = 6,
  parameter int BUF_DEPTH = 16,
  parameter int ADDR_W    = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [1:0]              cfg_pool,
  input  logic [COL_W-1:0]        cfg_row_len,
  input  logic [MAP_W-1:0]        cfg_map_cnt,
  input  logic [MAP_W-1:0]        cfg_map_base,
  input  logic [NUM_PE-1:0]       pe_valid,
  input  logic [NUM_PE*RES_W-1:0] pe_result,
  output logic                    bias_rd_en,
  output logic [MAP_W-1:0]        bias_rd_addr,
  input  logic [RES_W-1:0]        bias_rd_data,
  output logic                    fm_we,
  output logic [ADDR_W-1:0]       fm_addr,
  output logic [RES_W-1:0]        fm_wdata
);
  localparam int IDX_W = $clog2(NUM_PE);
  localparam int PX_W  = $clog2(BUF_DEPTH);

  logic [1:0]       cfg_pool_q;
  logic [COL_W-1:0] cfg_row_q;
  logic [MAP_W-1:0] cfg_cnt_q, cfg_base_q;
  logic [1:0]       win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_pool_q <= '0; cfg_row_q <= '0; cfg_cnt_q <= '0; cfg_base_q <= '0;
    end else if (cfg_load) begin
      cfg_pool_q <= cfg_pool; cfg_row_q <= cfg_row_len;
      cfg_cnt_q  <= cfg_map_cnt; cfg_base_q <= cfg_map_base;
    end
  end

  assign win = rc_pkg::window_side(cfg_pool_q);

  // Named internal events, also used by the bound checker.
  logic [NUM_PE-1:0] pending, grant_oh;
  logic              grant_valid, s1_valid;
  logic [IDX_W-1:0]  grant_idx;
  logic [RES_W-1:0]  grant_data;
  logic              sel_first, sel_last;
  logic [PX_W-1:0]   sel_px;
  logic [ADDR_W-1:0] sel_oidx;

  rc_grant_arbiter #(.NUM_PE(NUM_PE), .RES_W(RES_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pe_valid(pe_valid), .pe_result(pe_result),
    .pending(pending), .grant_oh(grant_oh), .grant_valid(grant_valid),
    .grant_idx(grant_idx), .grant_data(grant_data)
  );

  rc_window_tracker #(.NUM_PE(NUM_PE), .COL_W(COL_W), .PX_W(PX_W), .ADDR_W(ADDR_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .win(win), .row_len(cfg_row_q),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .sel_first(sel_first),
    .sel_last(sel_last), .sel_px(sel_px), .sel_oidx(sel_oidx)
  );

  assign bias_rd_en   = grant_valid;
  assign bias_rd_addr = cfg_base_q + MAP_W'(grant_idx);

  rc_bias_pool_stage #(.NUM_PE(NUM_PE), .RES_W(RES_W), .MAP_W(MAP_W), .ADDR_W(ADDR_W), .PX_W(PX_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .grant_idx(grant_idx),
    .grant_data(grant_data), .sel_first(sel_first), .sel_last(sel_last),
    .sel_px(sel_px), .sel_oidx(sel_oidx), .bias_data(bias_rd_data),
    .map_cnt(cfg_cnt_q), .map_base(cfg_base_q), .s1_valid(s1_valid),
    .fm_we(fm_we), .fm_addr(fm_addr), .fm_wdata(fm_wdata)
  );
endmodule

// File: rtl/result_collector_chk.sv
module result_collector_chk #(
  parameter int NUM_PE = 4,
  parameter int MAP_W  = 6,
  localparam int IDX_W = $clog2(NUM_PE)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_PE-1:0] pe_valid,
  input logic [NUM_PE-1:0] pending,
  input logic [NUM_PE-1:0] grant_oh,
  input logic              grant_valid,
  input logic [IDX_W-1:0]  grant_idx,
  input logic              bias_rd_en,
  input logic [MAP_W-1:0]  bias_rd_addr,
  input logic [MAP_W-1:0]  cfg_base_q,
  input logic              s1_valid,
  input logic              fm_we
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) !rst_n |=> !fm_we);

  for (genvar i = 0; i < NUM_PE; i++) begin : g_prio
    assert_lowest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && pending[i]) |-> (grant_idx <= IDX_W'(i)));
  end

  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_valid & pending & ~grant_oh) == '0);

  assert_bias_before_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> $past(bias_rd_en));

  assert_write_after_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fm_we |-> $past(s1_valid));

  assert_bias_addr_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bias_rd_en |-> (MAP_W'(bias_rd_addr - cfg_base_q) < MAP_W'(NUM_PE)));
endmodule

bind result_collector result_collector_chk #(.NUM_PE(NUM_PE), .MAP_W(MAP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pe_valid(pe_valid), .pending(pending), .grant_oh(grant_oh),
  .grant_valid(grant_valid), .grant_idx(grant_idx), .bias_rd_en(bias_rd_en),
  .bias_rd_addr(bias_rd_addr), .cfg_base_q(cfg_base_q), .s1_valid(s1_valid), .fm_we(fm_we)
);

// File: tb/test_result_collector.sv
`timescale 1ns/1ps
module test_result_collector;
  localparam int NUM_PE = 4, RES_W = 16, MAP_W = 6, COL_W = 6, BUF_DEPTH = 16, ADDR_W = 14;

  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0;
  logic [1:0] cfg_pool = '0;
  logic [COL_W-1:0] cfg_row_len = '0;
  logic [MAP_W-1:0] cfg_map_cnt = '0, cfg_map_base = '0;
  logic [NUM_PE-1:0] pe_valid = '0;
  logic [NUM_PE*RES_W-1:0] pe_result = '0;
  logic bias_rd_en, fm_we;
  logic [MAP_W-1:0] bias_rd_addr;
  logic [RES_W-1:0] bias_rd_data, fm_wdata;
  logic [ADDR_W-1:0] fm_addr;

  result_collector #(.NUM_PE(NUM_PE), .RES_W(RES_W), .MAP_W(MAP_W), .COL_W(COL_W),
                     .BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) i_result_collector (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_pool(cfg_pool),
    .cfg_row_len(cfg_row_len), .cfg_map_cnt(cfg_map_cnt), .cfg_map_base(cfg_map_base),
    .pe_valid(pe_valid), .pe_result(pe_result), .bias_rd_en(bias_rd_en),
    .bias_rd_addr(bias_rd_addr), .bias_rd_data(bias_rd_data), .fm_we(fm_we),
    .fm_addr(fm_addr), .fm_wdata(fm_wdata)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bias memory model with one-cycle read latency.
  int bias_mem [64];
  logic [RES_W-1:0] bias_q = '0;
  assign bias_rd_data = bias_q;
  always @(posedge clk) if (bias_rd_en) bias_q <= RES_W'(bias_mem[bias_rd_addr]);

  int checks = 0, errors = 0, done = 0;
  string tag = "R1";
  int m_win = 1, m_row = 1, m_cnt = 1, m_base = 0;
  int hist [NUM_PE][256];
  int cnt [NUM_PE];
  int ea [NUM_PE][256];
  int ed [NUM_PE][256];
  int hd [NUM_PE];
  int tl [NUM_PE];
  int log_pe [64];
  int log_cyc [64];
  int log_n = 0;
  int pv [NUM_PE];
  int drive_cyc = 0;
  int mon_a, mon_d, mon_p;

  function automatic int sat(input int s);
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Rebuild each element's map and emit the expected write when a value ends a window.
  task automatic model_push(input int p, input int v);
    int s, n, x, y, m, k;
    s = sat(v + bias_mem[m_base + p]);
    n = cnt[p];
    hist[p][n] = s;
    cnt[p] = n + 1;
    x = n % m_row;
    y = n / m_row;
    if (m_win == 1) begin
      ea[p][tl[p]] = n * m_cnt + m_base + p; ed[p][tl[p]] = s; tl[p]++;
    end else if ((x % m_win == m_win - 1) && (y % m_win == m_win - 1)) begin
      m = -100000;
      for (int dy = 0; dy < m_win; dy++)
        for (int dx = 0; dx < m_win; dx++)
          if (hist[p][(y - dy) * m_row + (x - dx)] > m) m = hist[p][(y - dy) * m_row + (x - dx)];
      k = (y / m_win) * (m_row / m_win) + x / m_win;
      ea[p][tl[p]] = k * m_cnt + m_base + p; ed[p][tl[p]] = m; tl[p]++;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && fm_we) begin
      mon_a = int'(fm_addr);
      mon_d = int'($signed(fm_wdata));
      mon_p = (mon_a % m_cnt) - m_base;
      if (log_n < 64) begin log_pe[log_n] = mon_p; log_cyc[log_n] = cyc; log_n++; end
      if (mon_p < 0 || mon_p >= NUM_PE || hd[mon_p] == tl[mon_p]) begin
        check(1'b0, {tag, " unexpected write"}, mon_a, -1);
      end else begin
        check(mon_a == ea[mon_p][hd[mon_p]], {tag, " address"}, mon_a, ea[mon_p][hd[mon_p]]);
        check(mon_d == ed[mon_p][hd[mon_p]], {tag, " data"}, mon_d, ed[mon_p][hd[mon_p]]);
        hd[mon_p]++;
      end
    end
  end

  task automatic send(input logic [NUM_PE-1:0] mask);
    @(negedge clk);
    pe_valid = mask;
    for (int p = 0; p < NUM_PE; p++) begin
      pe_result[p*RES_W +: RES_W] = RES_W'(pv[p]);
      if (mask[p]) model_push(p, pv[p]);
    end
    drive_cyc = cyc;
    @(negedge clk);
    pe_valid = '0;
    repeat (NUM_PE) @(negedge clk);
  endtask

  task automatic cfg_set(input int mode, input int row, input int zc, input int base);
    @(negedge clk);
    cfg_pool = 2'(mode); cfg_row_len = COL_W'(row); cfg_map_cnt = MAP_W'(zc); cfg_map_base = MAP_W'(base);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_win = (mode == 1) ? 2 : (mode == 2) ? 3 : 1;
    m_row = row; m_cnt = zc; m_base = base;
    for (int p = 0; p < NUM_PE; p++) begin cnt[p] = 0; hd[p] = 0; tl[p] = 0; end
  endtask

  task automatic expect_drained(input string req);
    repeat (10) @(negedge clk);
    for (int p = 0; p < NUM_PE; p++) check(hd[p] == tl[p], {req, " missing writes"}, tl[p] - hd[p], 0);
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    int d0;
    void'($urandom(32'd7331));
    for (int i = 0; i < 64; i++) bias_mem[i] = int'($urandom_range(4000)) - 2000;
    bias_mem[2] = 1500;
    bias_mem[3] = -1500;
    for (int p = 0; p < NUM_PE; p++) begin cnt[p] = 0; hd[p] = 0; tl[p] = 0; pv[p] = 0; end

    // R1: quiet during and after reset
    repeat (3) @(negedge clk);
    check(fm_we == 1'b0, "R1 fm_we in reset", int'(fm_we), 0);
    check(bias_rd_en == 1'b0, "R1 bias_rd_en in reset", int'(bias_rd_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(fm_we == 1'b0, "R1 fm_we after reset", int'(fm_we), 0);
    check(bias_rd_en == 1'b0, "R1 bias_rd_en after reset", int'(bias_rd_en), 0);

    // No pooling: latency and bias address (R2, R3)
    cfg_set(0, 4, 8, 2);
    tag = "R3";
    pv[2] = 100; log_n = 0;
    send(4'b0100);
    check(log_n == 1, "R2 single write count", log_n, 1);
    check(log_cyc[0] - drive_cyc == 3, "R2 write latency", log_cyc[0] - drive_cyc, 3);

    // R5: simultaneous arrivals in ascending order on consecutive cycles
    tag = "R5";
    for (int p = 0; p < NUM_PE; p++) pv[p] = rnd16();
    log_n = 0;
    send(4'b1111);
    d0 = drive_cyc;
    repeat (2) @(negedge clk);
    check(log_n == NUM_PE, "R5 write count", log_n, NUM_PE);
    for (int i = 0; i < NUM_PE; i++) begin
      check(log_pe[i] == i, "R5 order", log_pe[i], i);
      check(log_cyc[i] == d0 + 3 + i, "R5 cycle", log_cyc[i] - d0, 3 + i);
    end

    // R4: saturation at both ends
    tag = "R4";
    pv[0] = 32767; pv[1] = -32768;
    send(4'b0011);

    // R2: random traffic without pooling
    tag = "R2";
    for (int i = 0; i < 40; i++) begin
      for (int p = 0; p < NUM_PE; p++) pv[p] = rnd16();
      send(NUM_PE'($urandom_range(15, 1)));
    end
    expect_drained("R2");

    // R6: 2x2 windows
    cfg_set(1, 6, 4, 0);
    tag = "R6";
    for (int i = 0; i < 70; i++) begin
      for (int p = 0; p < NUM_PE; p++) pv[p] = rnd16();
      send(NUM_PE'($urandom_range(15, 1)));
    end
    expect_drained("R6");

    // R7: 3x3 windows
    cfg_set(2, 9, 6, 1);
    tag = "R7";
    for (int i = 0; i < 80; i++) begin
      for (int p = 0; p < NUM_PE; p++) pv[p] = rnd16();
      send(($urandom_range(3) == 0) ? NUM_PE'($urandom_range(15, 1)) : 4'b1111);
    end
    expect_drained("R7");

    // R8: selector 3 behaves as no pooling
    cfg_set(3, 5, 5, 0);
    tag = "R8";
    for (int i = 0; i < 15; i++) begin
      for (int p = 0; p < NUM_PE; p++) pv[p] = rnd16();
      send(NUM_PE'($urandom_range(15, 1)));
    end
    expect_drained("R8");

    // R9: reload drops a partial window and restarts the index
    cfg_set(1, 4, 4, 0);
    tag = "R9";
    for (int i = 0; i < 3; i++) begin pv[0] = 20000 + i; send(4'b0001); end
    cfg_set(1, 4, 4, 0);
    for (int i = 0; i < 8; i++) begin pv[0] = rnd16(); send(4'b0001); end
    expect_drained("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (done == 0) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule